// File: doc/BRIEF.md
# Wake pulse sequencer

This block sits on the host side of a satellite-navigation receiver that has a single power-control input. The receiver reacts only to the rising edge of a short low-high-low pulse on that input. The first pulse after power-up wakes the receiver, and every later pulse moves it between hibernate and full navigation. The sequencer turns host requests and a bounce-prone push button into clean pulses of a fixed width. It keeps a guard interval between any two rising edges. It also tracks which state it believes the receiver is in.

After reset the block waits for the receiver's startup delay and then sends a wake pulse. It repeats that pulse once per guard interval until the receiver's wake-status line reports it is awake. A cold receiver can take several seconds to start, so the retries never stop. Once a configured number of attempts has gone unanswered, an error flag is raised and stays up until the acknowledgement arrives.

After the acknowledgement, the block accepts three kinds of request. A host wake request is honoured only while the wake-status line is low. A host sleep request is honoured only while it is high. A debounced button press always toggles the receiver. All timing comes from one tick prescaler, and every interval is given in ticks (one millisecond by default).

Top module: `wake_pulse_seq`

## Requirements
- R1: While reset is asserted, `ctrl_out`, `nav_state` and `boot_fail` are low and `busy` is high.
- R2: Every control pulse is high for exactly PULSE_MS ticks, which is PULSE_MS*(CLK_HZ/TICK_HZ) clock cycles, and then returns low.
- R3: Two rising edges of `ctrl_out` are never closer than GUARD_MS ticks. Consecutive boot retries are exactly GUARD_MS ticks apart.
- R4: The first wake pulse after reset release rises BOOT_MS ticks after the release, within one tick.
- R5: During the boot phase, the block samples `awake_in` at the end of the startup wait and again at the end of each guard interval. If it is low, another pulse is sent. If it is high, pulsing stops, `nav_state` goes high and `busy` goes low. If `awake_in` is already high when the startup wait ends, no pulse is sent at all.
- R6: `boot_fail` rises at the end of the guard interval of the MAX_TRIES-th unanswered boot pulse. Retries continue after that. `boot_fail` clears when the acknowledgement arrives.
- R7: A button press counts only after the button level has stayed high for DEBOUNCE_MS consecutive ticks. Shorter glitches, bursts of bounce and the release produce no pulse. A bouncy press followed by a steady level produces exactly one pulse.
- R8: `wake_req` is ignored while `awake_in` is high. `sleep_req` is ignored while `awake_in` is low. A button press toggles regardless of `awake_in`.
- R9: After the boot phase, `nav_state` inverts at the rising edge of every control pulse and changes at no other time.
- R10: Requests that arrive while `busy` is high (startup wait, pulse or guard interval) are dropped, not queued.
- R11: Requests that arrive together produce at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wake_req | input | 1 | Single-cycle host request to enter navigation |
| sleep_req | input | 1 | Single-cycle host request to enter hibernate |
| button_raw | input | 1 | Raw push-button level, active high, asynchronous |
| awake_in | input | 1 | Receiver wake-status line, high while awake, asynchronous |
| ctrl_out | output | 1 | Pulse to the receiver's power-control input |
| nav_state | output | 1 | Believed receiver state: 1 = navigation, 0 = hibernate |
| busy | output | 1 | High during the startup wait, a pulse, or a guard interval |
| boot_fail | output | 1 | Boot wake attempts exhausted without acknowledgement |

## Verification
The boot phase is driven three ways:
- an acknowledgement that never comes until after the error threshold, which separates the retry spacing, the error flag and its clearing;
- an acknowledgement already present at power-up, which shows that no pulse is sent at all;
- the normal startup, which fixes the first-pulse delay.

In the request table, each request kind is paired with both wake-status levels. This tells a honoured request apart from a filtered one, and shows that the button toggles regardless of status. A row with simultaneous wake and sleep requests shows that only one pulse results. The button is also given a short glitch, a bounce burst before a steady press, and a request sent during a guard interval. These separate the debounce filter and the dropping of busy-time requests from the normal toggle path.

// File: rtl/wps_pkg.sv
package wps_pkg;

  typedef enum logic [1:0] {
    SEQ_BOOT  = 2'd0,
    SEQ_FIRE  = 2'd1,
    SEQ_GUARD = 2'd2,
    SEQ_IDLE  = 2'd3
  } seq_state_e;

  function automatic int unsigned cwidth(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wps_tick_gen.sv
module wps_tick_gen #(
  parameter int unsigned DIV = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = wps_pkg::cwidth(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == LAST);

  always_comb begin
    if (clr || tick) cnt_n = '0;
    else             cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/wps_sync.sv
module wps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_n;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_n = d;
    end else begin : g_multi
      assign chain_n = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wps_debounce.sv
module wps_debounce #(
  parameter int unsigned HOLD_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level_in,
  output logic press
);
  localparam int unsigned CW = wps_pkg::cwidth(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          stable_q, stable_n;
  logic          prev_q;

  always_comb begin
    stable_n = stable_q;
    cnt_n    = cnt_q;
    if (level_in == stable_q) begin
      cnt_n = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        stable_n = level_in;
        cnt_n    = '0;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      stable_q <= 1'b0;
      prev_q   <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      stable_q <= stable_n;
      prev_q   <= stable_q;
    end
  end

  assign press = stable_q & ~prev_q;
endmodule

// File: rtl/wake_pulse_seq.sv
module wake_pulse_seq #(
  parameter int unsigned CLK_HZ      = 16_000_000,
  parameter int unsigned TICK_HZ     = 1000,
  parameter int unsigned PULSE_MS    = 100,
  parameter int unsigned GUARD_MS    = 1000,
  parameter int unsigned BOOT_MS     = 300,
  parameter int unsigned DEBOUNCE_MS = 20,
  parameter int unsigned MAX_TRIES   = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  input  logic sleep_req,
  input  logic button_raw,
  input  logic awake_in,
  output logic ctrl_out,
  output logic nav_state,
  output logic busy,
  output logic boot_fail
);
  import wps_pkg::*;

  localparam int unsigned DIV     = CLK_HZ / TICK_HZ;
  localparam int unsigned SPAN    = (GUARD_MS > BOOT_MS) ? GUARD_MS : BOOT_MS;
  localparam int unsigned TW      = cwidth(SPAN + 1);
  localparam int unsigned RW      = cwidth(MAX_TRIES + 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(PULSE_MS - 1);
  localparam logic [TW-1:0] GUARD_LAST = TW'(GUARD_MS - 1);
  localparam logic [TW-1:0] BOOT_LAST  = TW'(BOOT_MS - 1);
  localparam logic [RW-1:0] TRY_LIMIT  = RW'(MAX_TRIES);

  logic tick, launch;
  logic awake_s, button_s, press;

  seq_state_e    state_q, state_n;
  logic [TW-1:0] elapsed_q, elapsed_n;
  logic [RW-1:0] tries_q, tries_n;
  logic          booting_q, booting_n;
  logic          nav_q, nav_n;
  logic          fail_q, fail_n;
  logic          ctrl_q, ctrl_n;
  logic          req_ok;

  wps_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(launch), .tick(tick)
  );

  wps_sync #(.STAGES(SYNC_STAGES)) u_sync_awake (
    .clk(clk), .rst_n(rst_n), .d(awake_in), .q(awake_s)
  );

  wps_sync #(.STAGES(SYNC_STAGES)) u_sync_button (
    .clk(clk), .rst_n(rst_n), .d(button_raw), .q(button_s)
  );

  wps_debounce #(.HOLD_TICKS(DEBOUNCE_MS)) u_debounce (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level_in(button_s), .press(press)
  );

  // A request is valid only if it would move the receiver away from its
  // reported state; the button is a plain toggle.
  assign req_ok = (wake_req & ~awake_s) | (sleep_req & awake_s) | press;

  always_comb begin
    state_n   = state_q;
    elapsed_n = elapsed_q;
    tries_n   = tries_q;
    booting_n = booting_q;
    nav_n     = nav_q;
    fail_n    = fail_q;
    launch    = 1'b0;

    unique case (state_q)
      SEQ_BOOT: begin
        if (tick) begin
          if (elapsed_q == BOOT_LAST) begin
            elapsed_n = '0;
            if (awake_s) begin
              booting_n = 1'b0;
              nav_n     = 1'b1;
              fail_n    = 1'b0;
              state_n   = SEQ_IDLE;
            end else begin
              launch = 1'b1;
            end
          end else begin
            elapsed_n = elapsed_q + TW'(1);
          end
        end
      end
      SEQ_FIRE: begin
        if (tick) begin
          elapsed_n = elapsed_q + TW'(1);
          if (elapsed_q == PULSE_LAST) state_n = SEQ_GUARD;
        end
      end
      SEQ_GUARD: begin
        if (tick) begin
          if (elapsed_q == GUARD_LAST) begin
            elapsed_n = '0;
            if (!booting_q) begin
              state_n = SEQ_IDLE;
            end else if (awake_s) begin
              booting_n = 1'b0;
              nav_n     = 1'b1;
              fail_n    = 1'b0;
              state_n   = SEQ_IDLE;
            end else begin
              if (tries_q >= TRY_LIMIT) fail_n = 1'b1;
              launch = 1'b1;
            end
          end else begin
            elapsed_n = elapsed_q + TW'(1);
          end
        end
      end
      SEQ_IDLE: begin
        if (req_ok) launch = 1'b1;
      end
      default: state_n = SEQ_IDLE;
    endcase

    if (launch) begin
      state_n   = SEQ_FIRE;
      elapsed_n = '0;
      if (booting_q) begin
        if (tries_q != TRY_LIMIT) tries_n = tries_q + RW'(1);
      end else begin
        nav_n = ~nav_q;
      end
    end

    ctrl_n = (state_n == SEQ_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_BOOT;
      elapsed_q <= '0;
      tries_q   <= '0;
      booting_q <= 1'b1;
      nav_q     <= 1'b0;
      fail_q    <= 1'b0;
      ctrl_q    <= 1'b0;
    end else begin
      state_q   <= state_n;
      elapsed_q <= elapsed_n;
      tries_q   <= tries_n;
      booting_q <= booting_n;
      nav_q     <= nav_n;
      fail_q    <= fail_n;
      ctrl_q    <= ctrl_n;
    end
  end

  assign ctrl_out  = ctrl_q;
  assign nav_state = nav_q;
  assign busy      = (state_q != SEQ_IDLE);
  assign boot_fail = fail_q;
endmodule

// File: rtl/wake_pulse_seq_chk.sv
module wake_pulse_seq_chk #(
  parameter int unsigned PULSE_CYC = 100,
  parameter int unsigned GUARD_CYC = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic ctrl_out,
  input logic nav_state,
  input logic busy,
  input logic boot_fail
);
  localparam int unsigned CW = wps_pkg::cwidth(GUARD_CYC + 2);
  localparam logic [CW-1:0] GSAT = CW'(GUARD_CYC);

  logic [CW-1:0] gap_q, hi_q;
  logic          ctrl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GSAT;
      hi_q   <= '0;
      ctrl_d <= 1'b0;
    end else begin
      ctrl_d <= ctrl_out;
      if (ctrl_out && !ctrl_d)  gap_q <= CW'(1);
      else if (gap_q != GSAT)   gap_q <= gap_q + CW'(1);
      if (ctrl_out) hi_q <= hi_q + CW'(1);
      else          hi_q <= '0;
    end
  end

  // R3
  guard_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_out) |-> (gap_q >= GSAT));

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_out) |-> (hi_q == CW'(PULSE_CYC)));

  // R9
  nav_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nav_state) |-> ($rose(ctrl_out) || $fell(busy)));

  // R10
  ctrl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out |-> busy);

  // R6
  fail_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |-> !nav_state);
endmodule

bind wake_pulse_seq wake_pulse_seq_chk #(
  .PULSE_CYC(PULSE_MS * (CLK_HZ / TICK_HZ)),
  .GUARD_CYC(GUARD_MS * (CLK_HZ / TICK_HZ))
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_out(ctrl_out), .nav_state(nav_state),
  .busy(busy), .boot_fail(boot_fail)
);

// File: tb/sim_wake_pulse_seq.sv
`timescale 1ns/1ps
module sim_wake_pulse_seq;
  localparam int CLK_HZ = 4000, TICK_HZ = 1000, DIV = CLK_HZ / TICK_HZ;
  localparam int PULSE = 3, GUARD = 10, BOOT = 5, DEB = 4, TRIES = 3;
  localparam int PULSE_CYC = PULSE * DIV, GUARD_CYC = GUARD * DIV, BOOT_CYC = BOOT * DIV;
  localparam int HOLD_CYC = (DEB + 2) * DIV;

  // {wake, sleep, button, awake, expected pulse, expected nav_state}
  localparam logic [5:0] VEC [8] = '{
    6'b100101, 6'b010110, 6'b010000, 6'b100011,
    6'b001110, 6'b001011, 6'b110110, 6'b100011
  };

  logic clk = 1'b0;
  logic rst_n, wake_req, sleep_req, button_raw, awake_in;
  logic ctrl_out, nav_state, busy, boot_fail;

  int cyc = 0, rises = 0, last_rise = 0, last_gap = 0, last_width = 0;
  int checks = 0, errors = 0;
  logic mon_prev = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ctrl_out && !mon_prev) begin
      last_gap  = cyc - last_rise;
      last_rise = cyc;
      rises++;
    end
    if (!ctrl_out && mon_prev) last_width = cyc - last_rise;
    mon_prev = ctrl_out;
  end

  wake_pulse_seq #(
    .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .PULSE_MS(PULSE), .GUARD_MS(GUARD),
    .BOOT_MS(BOOT), .DEBOUNCE_MS(DEB), .MAX_TRIES(TRIES), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
    .button_raw(button_raw), .awake_in(awake_in), .ctrl_out(ctrl_out),
    .nav_state(nav_state), .busy(busy), .boot_fail(boot_fail)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic press_button(input int high_cyc);
    button_raw = 1'b1;
    step(high_cyc);
    button_raw = 1'b0;
    step(HOLD_CYC);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin : main
    int rel_cyc, r0, gap;
    rst_n = 1'b0; wake_req = 1'b0; sleep_req = 1'b0; button_raw = 1'b0; awake_in = 1'b0;
    step(4);
    // R1 reset state
    check(!ctrl_out, "R1 ctrl_out in reset", ctrl_out, 0);
    check(!nav_state && !boot_fail, "R1 nav/fail in reset", {nav_state, boot_fail}, 0);
    check(busy, "R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    rel_cyc = cyc;

    // R4 first pulse delay
    wait (rises == 1);
    step(1);
    gap = last_rise - rel_cyc;
    check(gap >= BOOT_CYC && gap <= BOOT_CYC + DIV, "R4 first pulse delay", gap, BOOT_CYC);

    // R3 R2 retry spacing and width
    wait (rises == 2);
    step(1);
    check(last_gap == GUARD_CYC, "R3 retry spacing", last_gap, GUARD_CYC);
    check(last_width == PULSE_CYC, "R2 pulse width", last_width, PULSE_CYC);
    check(busy && !nav_state, "R5 still booting", {busy, nav_state}, 2);

    // R6 error flag threshold
    wait (rises == 3);
    step(1);
    check(!boot_fail, "R6 flag before limit", boot_fail, 0);
    wait (rises == 4);
    step(1);
    check(boot_fail, "R6 flag after limit", boot_fail, 1);
    check(last_gap == GUARD_CYC, "R3 retry spacing after flag", last_gap, GUARD_CYC);
    awake_in = 1'b1;
    step(GUARD_CYC + 10);
    check(rises == 4, "R5 retries stop on ack", rises, 4);
    check(nav_state && !busy, "R5 nav after ack", {nav_state, busy}, 2);
    check(!boot_fail, "R6 flag clears on ack", boot_fail, 0);

    // R8 R9 R11 request table
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = VEC[i];
      awake_in = v[2];
      step(4);
      r0 = rises;
      if (v[5] || v[4]) begin
        wake_req = v[5]; sleep_req = v[4];
        step(1);
        wake_req = 1'b0; sleep_req = 1'b0;
      end
      if (v[3]) press_button(HOLD_CYC);
      step(GUARD_CYC + 8);
      check(rises - r0 == int'(v[1]), $sformatf("R8 R11 row %0d pulse count", i), rises - r0, v[1]);
      check(nav_state == v[0], $sformatf("R9 row %0d nav_state", i), nav_state, v[0]);
      if (v[1]) check(last_width == PULSE_CYC, $sformatf("R2 row %0d width", i), last_width, PULSE_CYC);
    end

    // R10 request during guard is dropped (nav=1 here)
    awake_in = 1'b1;
    step(2);
    r0 = rises;
    sleep_req = 1'b1; step(1); sleep_req = 1'b0;
    step(5);
    check(busy && ctrl_out, "R10 busy during pulse", {busy, ctrl_out}, 3);
    awake_in = 1'b0;
    step(15);
    wake_req = 1'b1; step(1); wake_req = 1'b0;
    step(GUARD_CYC + 8);
    check(rises - r0 == 1, "R10 busy request dropped", rises - r0, 1);
    check(!nav_state, "R10 nav unchanged by dropped request", nav_state, 0);

    // R7 short glitch
    r0 = rises;
    press_button(2 * DIV);
    step(GUARD_CYC);
    check(rises == r0, "R7 glitch ignored", rises - r0, 0);

    // R7 bounce burst then steady press
    r0 = rises;
    for (int k = 0; k < 10; k++) begin
      button_raw = ~button_raw;
      step(3);
    end
    press_button(HOLD_CYC);
    step(GUARD_CYC + 8);
    check(rises - r0 == 1, "R7 bounce gives one pulse", rises - r0, 1);
    check(nav_state, "R7 R9 nav toggled by button", nav_state, 1);

    // R5 receiver already awake at power-up
    awake_in = 1'b1;
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    r0 = rises;
    step(BOOT_CYC + GUARD_CYC);
    check(rises == r0, "R5 no pulse when already awake", rises - r0, 0);
    check(nav_state && !busy, "R5 nav without pulse", {nav_state, busy}, 2);

    finish_run();
  end
endmodule